// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the final keep-or-drop decision for each received Ethernet frame. When the MAC reaches the end of a frame, it presents a frame-end strobe along with three things: the destination address, a flag saying whether the frame was well formed, and the verdict of its own address filter. One cycle later the filter answers with either an accept pulse or a reject pulse. The reject pulse is meant to feed an interrupt status bit.

Software-visible settings are loaded through a simple write port. They are:
- a unicast station address;
- four multicast table entries, each with its own valid bit;
- a control word holding a promiscuous bit, a multicast-reject bit and a broadcast-reject bit.

The build parameter `EXT_MCAST` selects a variant in which multicast filtering is handled elsewhere. In that variant every frame is dropped unless promiscuous mode is on.

Top module: `rx_addr_filter`

## Requirements
- R1: A frame with `frm_good` low at the frame-end strobe is rejected, whatever its address and the configuration.
- R2: A good frame with `mac_match` low is accepted when any of these holds: its destination equals the unicast register, it is broadcast, it hits a valid multicast entry, or promiscuous mode is on. Otherwise it is rejected.
- R3: The multicast table has four entries, written at `cfg_addr` 1 to 4 with `cfg_wdata[47:0]` as the address and `cfg_wdata[48]` as the valid bit. An entry whose valid bit is clear never matches.
- R4: With `EXT_MCAST`=1 and promiscuous mode off, every frame is rejected.
- R5: A good frame with `mac_match` high is rejected if it is multicast and the multicast-reject bit is set. A frame is multicast when bit 40 of `frm_dst` (bit 0 of the first octet) is set and the address is not all ones.
- R6: A good frame with `mac_match` high is rejected if it is broadcast (all 48 bits one) and the broadcast-reject bit is set.
- R7: A good frame with `mac_match` high that neither R5 nor R6 rejects is accepted, provided R4 does not apply.
- R8: Exactly one of `acc_pulse` and `rej_pulse` is high for one cycle, in the cycle after each `frm_end`. Both stay low in every other cycle.
- R9: Reset clears all configuration: the unicast address becomes zero, promiscuous and both reject bits become zero, and every table entry becomes invalid. Both pulses are low during reset.
- R10: A write at `cfg_addr` 0 loads the unicast address from `cfg_wdata[47:0]`. A write at `cfg_addr` 5 loads promiscuous from bit 0, multicast-reject from bit 1 and broadcast-reject from bit 2. A write made in the same cycle as `frm_end` does not affect that frame's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 49 | Configuration write data |
| frm_end | input | 1 | Frame-end strobe; the frame inputs are valid in this cycle |
| frm_dst | input | 48 | Destination address; the first octet is in bits 47:40 |
| frm_good | input | 1 | MAC found no FCS or length error |
| mac_match | input | 1 | MAC's own address filter passed |
| acc_pulse | output | 1 | One-cycle accept |
| rej_pulse | output | 1 | One-cycle reject event |

## Verification
The bench builds two copies of the block that share the same stimulus, one with `EXT_MCAST`=0 and one with `EXT_MCAST`=1. Every frame sent is therefore checked against both variants.

The `EXT_MCAST`=0 copy covers each path through the decision: the frame-quality check, fallback matching after the MAC filter fails, and the reject overrides after it passes. The `EXT_MCAST`=1 copy shows that forced rejection applies only while promiscuous mode is off, and that the normal path takes over once it is on.

Both copies use the default four-entry table, so every entry can be hit and invalidated individually.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_W    = 48,
  parameter int NUM_MC    = 4,
  parameter bit EXT_MCAST = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  logic [$clog2(NUM_MC+2)-1:0]  cfg_addr,
  input  logic [ADDR_W:0]              cfg_wdata,
  input  logic                         frm_end,
  input  logic [ADDR_W-1:0]            frm_dst,
  input  logic                         frm_good,
  input  logic                         mac_match,
  output logic                         acc_pulse,
  output logic                         rej_pulse
);
  localparam int SEL_W = $clog2(NUM_MC + 2);
  localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_MC + 1);

  logic [ADDR_W-1:0] uc_addr;
  logic [ADDR_W-1:0] mc_addr [NUM_MC];
  logic [NUM_MC-1:0] mc_vld;
  logic              promisc, mc_rej, bc_rej;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uc_addr <= '0;
      mc_vld  <= '0;
      promisc <= 1'b0;
      mc_rej  <= 1'b0;
      bc_rej  <= 1'b0;
      for (int i = 0; i < NUM_MC; i++) mc_addr[i] <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == '0) uc_addr <= cfg_wdata[ADDR_W-1:0];
      if (cfg_addr == CTRL_SEL) begin
        promisc <= cfg_wdata[0];
        mc_rej  <= cfg_wdata[1];
        bc_rej  <= cfg_wdata[2];
      end
      for (int i = 0; i < NUM_MC; i++)
        if (cfg_addr == SEL_W'(i + 1)) begin
          mc_addr[i] <= cfg_wdata[ADDR_W-1:0];
          mc_vld[i]  <= cfg_wdata[ADDR_W];
        end
    end
  end

  logic [NUM_MC-1:0] mc_hit;
  always_comb
    for (int i = 0; i < NUM_MC; i++)
      mc_hit[i] = mc_vld[i] && (mc_addr[i] == frm_dst);

  wire is_bcast = &frm_dst;
  wire is_mcast = frm_dst[ADDR_W-8] && !is_bcast;
  wire uc_hit   = (frm_dst == uc_addr);
  wire soft_ok  = |mc_hit || is_bcast || uc_hit || promisc;
  wire pass_rej = (is_mcast && mc_rej) || (is_bcast && bc_rej);
  wire ext_rej  = EXT_MCAST && !promisc;
  wire drop     = !frm_good || ext_rej || (mac_match ? pass_rej : !soft_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_pulse <= 1'b0;
      rej_pulse <= 1'b0;
    end else begin
      acc_pulse <= frm_end && !drop;
      rej_pulse <= frm_end && drop;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) frm_end |=> (acc_pulse ^ rej_pulse)); // R8
  AST_NO_STRAY:    assert property (@(posedge clk) disable iff (!rst_n) !frm_end |=> !(acc_pulse || rej_pulse)); // R8
  AST_BAD_DROPS:   assert property (@(posedge clk) disable iff (!rst_n) (frm_end && !frm_good) |=> rej_pulse); // R1
  AST_EXT_DROPS:   assert property (@(posedge clk) disable iff (!rst_n) (EXT_MCAST && frm_end && !promisc) |=> rej_pulse); // R4
  AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (frm_end && frm_good && !mac_match && promisc) |=> acc_pulse); // R2
  AST_BCAST_VETO:  assert property (@(posedge clk) disable iff (!rst_n) (frm_end && frm_good && mac_match && is_bcast && bc_rej) |=> rej_pulse); // R6
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [48:0] cfg_wdata = '0;
  logic        frm_end = 1'b0;
  logic [47:0] frm_dst = '0;
  logic        frm_good = 1'b0;
  logic        mac_match = 1'b0;
  logic        acc, rej, e_acc, e_rej;
  int          vectors = 0, errs = 0;
  bit          done = 1'b0;
  bit          tb_promisc = 1'b0;

  always #4 clk = ~clk;

  rx_addr_filter #(.EXT_MCAST(1'b0)) u_rx_addr_filter (
    .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .frm_end, .frm_dst,
    .frm_good, .mac_match, .acc_pulse(acc), .rej_pulse(rej));

  rx_addr_filter #(.EXT_MCAST(1'b1)) u_ext (
    .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .frm_end, .frm_dst,
    .frm_good, .mac_match, .acc_pulse(e_acc), .rej_pulse(e_rej));

  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] UC  = 48'h0A1B_2C3D_4E5F;
  localparam logic [47:0] OTH = 48'h0200_0000_0001;
  localparam logic [47:0] MC0 = 48'h0100_5E00_0001;

  task automatic cmp(string tag, logic a, logic r, logic er);
    vectors++;
    if (a !== !er || r !== er) begin
      errs++;
      $display("FAIL %s: acc=%0b rej=%0b expected acc=%0b rej=%0b", tag, a, r, !er, er);
    end
  endtask

  task automatic cfg(logic [2:0] a, logic [48:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == 3'd5) tb_promisc = d[0];
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic frame(string tag, logic [47:0] dst, logic good, logic mm, logic exp_rej);
    @(negedge clk);
    frm_end = 1'b1; frm_dst = dst; frm_good = good; mac_match = mm;
    @(negedge clk);
    frm_end = 1'b0;
    cmp(tag, acc, rej, exp_rej);
    cmp({tag, " R4 ext"}, e_acc, e_rej, tb_promisc ? exp_rej : 1'b1);
    @(negedge clk);
    vectors++;
    if (acc || rej || e_acc || e_rej) begin
      errs++;
      $display("FAIL R8 %s: pulse lasted %0b%0b%0b%0b expected 0000", tag, acc, rej, e_acc, e_rej);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    vectors++;
    if (acc || rej) begin errs++; $display("FAIL R9: acc=%0b rej=%0b during reset expected 0 0", acc, rej); end
    rst_n = 1'b1;
    frame("R9 unicast reg zero", OTH, 1, 0, 1);
    frame("R9 reject bits clear", MC0, 1, 1, 0);
    frame("R9 R3 table invalid", MC0, 1, 0, 1);
  endtask

  task automatic t_bad();
    frame("R1 bad passing", OTH, 0, 1, 1);
    frame("R1 bad broadcast", BC, 0, 0, 1);
  endtask

  task automatic t_unicast();
    cfg(3'd0, {1'b0, UC});
    frame("R10 R2 unicast hit", UC, 1, 0, 0);
    frame("R2 unicast miss", OTH, 1, 0, 1);
    frame("R2 broadcast fallback", BC, 1, 0, 0);
    frame("R7 pass plain", OTH, 1, 1, 0);
  endtask

  task automatic t_table();
    cfg(3'd3, {1'b1, MC0});
    frame("R3 entry hit", MC0, 1, 0, 0);
    cfg(3'd3, {1'b0, MC0});
    frame("R3 entry invalidated", MC0, 1, 0, 1);
    for (int i = 1; i <= 4; i++) cfg(3'(i), {1'b1, MC0 + 48'(i)});
    for (int i = 1; i <= 4; i++) frame("R3 each entry", MC0 + 48'(i), 1, 0, 0);
    frame("R3 near miss", MC0 + 48'd9, 1, 0, 1);
  endtask

  task automatic t_promisc();
    cfg(3'd5, 49'h1);
    frame("R2 R4 promisc accept", OTH, 1, 0, 0);
    frame("R1 bad in promisc", OTH, 0, 0, 1);
    cfg(3'd5, 49'h0);
  endtask

  task automatic t_overrides();
    cfg(3'd5, 49'h2);
    frame("R5 multicast veto", MC0, 1, 1, 1);
    frame("R5 broadcast not multicast", BC, 1, 1, 0);
    frame("R7 unicast unaffected", OTH, 1, 1, 0);
    frame("R5 veto only when passing", MC0 + 48'd1, 1, 0, 0);
    cfg(3'd5, 49'h4);
    frame("R6 broadcast veto", BC, 1, 1, 1);
    frame("R6 multicast kept", MC0, 1, 1, 0);
    frame("R6 veto only when passing", BC, 1, 0, 0);
    cfg(3'd5, 49'h7);
    frame("R5 R6 promisc keeps veto", MC0, 1, 1, 1);
    cfg(3'd5, 49'h0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    frm_end = 1'b1; frm_dst = OTH; frm_good = 1'b1; mac_match = 1'b0;
    cfg_wr = 1'b1; cfg_addr = 3'd5; cfg_wdata = 49'h1;
    @(negedge clk);
    frm_end = 1'b0; cfg_wr = 1'b0;
    cmp("R10 write after decision", acc, rej, 1'b1);
    tb_promisc = 1'b1;
    frame("R10 write then applies", OTH, 1, 0, 0);
    cfg(3'd5, 49'h0);
  endtask

  initial begin
    t_reset();
    t_bad();
    t_unicast();
    t_table();
    t_promisc();
    t_overrides();
    t_same_cycle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule